// File: doc/BRIEF.md
# Sequential Shift-and-Add Unsigned Multiplier

This block multiplies two unsigned operands of parameter width W and handles one multiplier bit per clock. A start pulse captures the operands. The multiplicand goes into a holding register and the multiplier goes into a shift register. An accumulator is cleared at the same time. On each iteration, one of two values is added into the accumulator: the multiplicand if the current low multiplier bit is 1, or zero if it is 0. The adder carry, the accumulator and the multiplier register are then shifted right together as a single value, by one bit.

After W iterations the accumulator holds the upper half of the product and the multiplier register holds the lower half. The block then pulses a completion flag for one cycle. The product stays on its output until the next operation begins. A start request that arrives while an operation is running has no effect.

Top module: `seq_mul`

## Requirements
- R1: After reset, busy and done are 0 and product is 0.
- R2: When start is 1 and busy is 0 at a clock edge, the block captures a_in as the multiplier and b_in as the multiplicand. It sets busy to 1 in the following cycle.
- R3: busy stays 1 for exactly W consecutive cycles, one step per cycle, and then falls to 0.
- R4: done is 1 for exactly one cycle, in the cycle where busy has just fallen. At all other times done is 0.
- R5: When done is 1, product equals a_in × b_in as unsigned W-bit operands, computed as a full 2W-bit result with no truncation.
- R6: The carry from each W-bit addition is kept as the new top bit of the accumulator. All-ones operands therefore give (2^W−1)^2 exactly.
- R7: A start pulse seen while busy is 1 is ignored. The running operation still finishes W cycles after its own start with its own operands. The pulse does not extend busy or produce an extra done.
- R8: product keeps its value from the cycle of done until the next accepted start.
- R9: A zero operand on either side gives a product of 0. This includes a zero multiplier with an all-ones multiplicand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a multiplication |
| a_in | input | W | Multiplier operand |
| b_in | input | W | Multiplicand operand |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2W | Unsigned product {high, low} |

## Verification
Two cases are hard to reach from the ports. The first is a start that collides with an operation already running. This is most telling on the final iteration, when busy is about to drop. The bench therefore issues a second start with different operands at several offsets into a run, including the last busy cycle. It then checks that the result belongs to the first operation and that exactly one done appears.

The second case is the adder carry out of the top bit, which only matters when the accumulator is nearly full. The bench forces this case with all-ones operands and with random operands whose upper bits are set.

// File: rtl/seq_mul_pkg.sv
package seq_mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } mul_state_t;
endpackage

// File: rtl/seq_mul_ctrl.sv
module seq_mul_ctrl
  import seq_mul_pkg::*;
#(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  mul_state_t        state;
  logic [CW-1:0]     left;

  assign load = start && (state != ST_RUN);
  assign step = (state == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      left  <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_RUN: begin
          if (left == CW'(1)) begin
            state <= ST_DONE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end
          left <= left - CW'(1);
        end
        default: begin
          if (start) begin
            state <= ST_RUN;
            left  <= CW'(W);
            busy  <= 1'b1;
          end else begin
            state <= ST_IDLE;
          end
        end
      endcase
    end
  end

  // R3: the step counter never exceeds W and is nonzero while running
  a_r3_count_range: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |-> (left != '0 && left <= CW'(W)));
  // R4: done never coincides with busy
  a_r4_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));
  // R4: done only right after busy falls
  a_r4_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $fell(busy));
  // R7: start while running leaves the counter moving down
  a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && left > CW'(1) && start) |=> (left == $past(left) - CW'(1)));
endmodule

// File: rtl/seq_mul_dp.sv
module seq_mul_dp #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   b_in,
  output logic [2*W-1:0] product
);
  logic [W-1:0] acc_q;
  logic [W-1:0] mplr_q;
  logic [W-1:0] mcand_q;
  logic [W-1:0] addend;
  logic [W:0]   sum;

  assign addend  = mplr_q[0] ? mcand_q : '0;
  assign sum     = {1'b0, acc_q} + {1'b0, addend};
  assign product = {acc_q, mplr_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      mplr_q  <= '0;
      mcand_q <= '0;
    end else if (load) begin
      acc_q   <= '0;
      mplr_q  <= a_in;
      mcand_q <= b_in;
    end else if (step) begin
      acc_q   <= sum[W:1];
      mplr_q  <= {sum[0], mplr_q[W-1:1]};
    end
  end

  // R6: the carry of each add lands in the accumulator top bit
  a_r6_carry_kept: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (acc_q[W-1] == $past(sum[W])));
  // R8: product frozen when neither loading nor stepping
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(load) && !$past(step)) |-> $stable(product));
  // R2: a load clears the accumulator
  a_r2_load_clears: assert property (@(posedge clk) disable iff (rst)
    load |=> (acc_q == '0));
endmodule

// File: rtl/seq_mul.sv
module seq_mul #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   b_in,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  logic load;
  logic step;

  seq_mul_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .load(load), .step(step), .busy(busy), .done(done)
  );

  seq_mul_dp #(.W(W)) u_dp (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .a_in(a_in), .b_in(b_in), .product(product)
  );

  // R2: an accepted start raises busy next cycle
  a_r2_busy_rise: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
endmodule

// File: tb/sim_seq_mul.sv
module sim_seq_mul;
  localparam int W = 32;
  logic clk = 1'b0;
  logic rst;
  logic start;
  logic [W-1:0] a_in, b_in;
  logic busy, done;
  logic [2*W-1:0] product;
  int checks = 0;
  int errors = 0;
  logic timed_out = 1'b0;

  always #10 clk = ~clk;

  seq_mul #(.W(W)) u0 (
    .clk(clk), .rst(rst), .start(start), .a_in(a_in), .b_in(b_in),
    .busy(busy), .done(done), .product(product)
  );

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    return {{W{1'b0}}, a} * {{W{1'b0}}, b};
  endfunction

  task automatic check(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one operation; optionally injects a second start at offset inj (cycles after load, 1..W)
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input int inj, input string req);
    int busy_cnt = 0;
    int done_cnt = 0;
    logic [2*W-1:0] got = '0;
    @(negedge clk);
    a_in = a; b_in = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    a_in = ~a; b_in = b ^ 32'h5a5a_1234;
    check("R2 busy after start", {63'd0, busy}, 64'd1);
    for (int c = 1; c <= W + 3; c++) begin
      if (busy) busy_cnt++;
      if (done) begin done_cnt++; got = product; end
      if (c == inj) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    check({"R3 busy length ", req}, 64'(busy_cnt), 64'(W));
    check({"R4 done count ", req}, 64'(done_cnt), 64'd1);
    check({"R5 product ", req}, got, ref_mul(a, b));
    check({"R8 product held ", req}, product, ref_mul(a, b));
  endtask

  initial begin
    #(20 * 200000);
    timed_out = 1'b1;
    errors++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; start = 1'b0; a_in = '0; b_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy", {63'd0, busy}, 64'd0);
    check("R1 done", {63'd0, done}, 64'd0);
    check("R1 product", product, 64'd0);

    run_op('1, '1, 0, "R6 all ones");
    run_op(32'h0, '1, 0, "R9 zero multiplier");
    run_op('1, 32'h0, 0, "R9 zero multiplicand");
    run_op(32'h1, 32'h8000_0001, 0, "one");
    run_op(32'h8000_0000, 32'h8000_0000, 0, "R6 top bits");
    run_op(32'hdead_beef, 32'hcafe_f00d, 1, "R7 early restart");
    run_op(32'h1234_5678, 32'hffff_fff0, W / 2, "R7 mid restart");
    run_op(32'hf0f0_f0f0, 32'hffff_0001, W, "R7 last-cycle restart");
    for (int i = 0; i < 20; i++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom; rb = $urandom;
      if (i % 3 == 0) begin ra[W-1:W-4] = 4'hf; rb[W-1:W-4] = 4'hf; end
      run_op(ra, rb, (i % 4 == 0) ? (i % W) + 1 : 0, "random");
    end
    if (!timed_out) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule